// File: doc/BRIEF.md
# Flash calibration overlay remapper

This block sits beside the flash on the data side of a memory bus. It checks every read request against eight programmable overlay windows placed over flash address space. Software tunes calibration constants in a small calibration RAM. A data read that lands inside an enabled window is redirected to that RAM. For such a read the block raises a suppression signal that keeps the flash from driving its data. It reports the hit with the same latency that a flash read has, so the requester sees no timing difference. Instruction fetches and writes to flash addresses are never redirected.

Each window is described by a word-granular flash base address and a 4-bit size code. A window is a naturally aligned power of two of 8 to 512 bytes. Window n owns the n-th 512-byte slot of the calibration RAM, and data is placed from the bottom of the slot upward. The RAM can also be reached directly through a fixed address range. A module disable bit puts the RAM in a stopped state: all overlays are off, and any direct read or write to the RAM is answered with an error.

Top module: `cal_overlay_remap`

## Requirements
- R1: After reset every window is disabled, the disable bit is clear, and all outputs are low. A data read to any flash address produces no hit, no RAM strobe and no error.
- R2: Size code c in 1..7 selects a window of 2^(c+2) bytes (code 1 = 8 bytes, code 5 = 128 bytes, code 7 = 512 bytes). Code 0 and codes 8..15 disable the window.
- R3: Base address bits below the selected window size are ignored, so the window starts at the base rounded down to a multiple of its size. Base bits 1:0 are never stored.
- R4: On a hit in window n at byte offset o inside the window, `ram_addr` is n*512 + o.
- R5: When several enabled windows contain the address, the lowest-numbered window is reported and used for the RAM address.
- R6: A read with `req_ifetch` high never hits a window, so it produces no RAM strobe and no flash suppression.
- R7: A write to an address inside a window is not redirected. It raises no hit and no RAM write.
- R8: `ram_rd`, `ram_wr` and `ram_addr` are valid one cycle after the request. `resp_hit`, `resp_rgn`, `resp_flash_blk` and `resp_err` are valid LAT cycles after the request, with `resp_flash_blk` high exactly when `resp_hit` is high.
- R9: While the disable bit is set, no window hits, and a direct read or write inside the RAM range raises `resp_err` with no RAM strobe. Clearing the bit restores overlay hits and direct access.
- R10: With the disable bit clear, a direct access inside the 4 KiB range starting at CRAM_BASE drives `ram_rd` or `ram_wr` with the low 12 address bits. It raises no hit and no error, and it is served whatever the state of `req_ifetch`. When read and write are both high, the access is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one window descriptor |
| cfg_idx | input | 3 | Window number being written |
| cfg_base | input | 32 | Flash base byte address; bits 1:0 dropped |
| cfg_code | input | 4 | Window size code |
| dis_we | input | 1 | Write strobe for the disable bit |
| dis_val | input | 1 | New value of the disable bit |
| req_rd | input | 1 | Read request strobe |
| req_wr | input | 1 | Write request strobe |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_addr | input | 32 | Request byte address |
| ram_rd | output | 1 | Calibration RAM read strobe |
| ram_wr | output | 1 | Calibration RAM write strobe |
| ram_addr | output | 12 | Calibration RAM byte address |
| resp_hit | output | 1 | Read was served by an overlay window |
| resp_rgn | output | 3 | Number of the window that hit |
| resp_flash_blk | output | 1 | Keep flash data off the bus |
| resp_err | output | 1 | Access to the RAM while it is disabled |

## Verification
The bench builds the block with LAT = 3, so the one-cycle RAM strobe timing and the later response timing fall on different cycles. A strobe that arrives at the wrong stage shows up as a mismatch. It uses the default CRAM_BASE of 0x0030_0000, which keeps the direct RAM range clear of the flash windows under test. The eight-window default programs overlapping windows and both kinds of disabled code (0 and above 7). It also programs a misaligned base, which brings priority, the size boundaries and the alignment rounding into reach.

// File: rtl/cal_ovl_pkg.sv
package cal_ovl_pkg;

    localparam int OVL_ADDR_W   = 32;
    localparam int OVL_NUM_RGN  = 8;
    localparam int OVL_RGN_W    = $clog2(OVL_NUM_RGN);
    localparam int OVL_SLOT_AW  = 9;                         // 512-byte slot per window
    localparam int OVL_CODE_W   = 4;
    localparam int OVL_MAX_CODE = OVL_SLOT_AW - 2;           // largest code fitting a slot
    localparam int OVL_RAM_AW   = OVL_RGN_W + OVL_SLOT_AW;

    typedef struct packed {
        logic [OVL_ADDR_W-3:0] base_w;                       // word address of window base
        logic [OVL_CODE_W-1:0] code;
    } rgn_desc_t;

    typedef struct packed {
        logic                 hit;
        logic [OVL_RGN_W-1:0] rgn;
        logic                 err;
    } resp_t;

    typedef struct packed {
        logic                  ram_rd;
        logic                  ram_wr;
        logic [OVL_RAM_AW-1:0] ram_addr;
        resp_t                 resp;
    } front_t;

endpackage

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs
    import cal_ovl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [OVL_RGN_W-1:0]  cfg_idx,
    input  logic [OVL_ADDR_W-1:0] cfg_base,
    input  logic [OVL_CODE_W-1:0] cfg_code,
    input  logic                  dis_we,
    input  logic                  dis_val,
    output rgn_desc_t             desc_o [OVL_NUM_RGN],
    output logic                  dis_o
);

    typedef struct packed {
        rgn_desc_t [OVL_NUM_RGN-1:0] rgn;
        logic                        dis;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.rgn[cfg_idx].base_w = cfg_base[OVL_ADDR_W-1:2];
            cfg_d.rgn[cfg_idx].code   = cfg_code;
        end
        if (dis_we) begin
            cfg_d.dis = dis_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar g = 0; g < OVL_NUM_RGN; g++) begin : g_out
        assign desc_o[g] = cfg_q.rgn[g];
    end

    assign dis_o = cfg_q.dis;

endmodule

// File: rtl/ovl_window_match.sv
module ovl_window_match
    import cal_ovl_pkg::*;
(
    input  rgn_desc_t              desc [OVL_NUM_RGN],
    input  logic [OVL_ADDR_W-1:0]  addr,
    output logic                   any_hit,
    output logic [OVL_RGN_W-1:0]   hit_idx,
    output logic [OVL_SLOT_AW-1:0] hit_off
);

    logic [OVL_NUM_RGN-1:0] hit_v;
    logic [OVL_SLOT_AW-1:0] off_a [OVL_NUM_RGN];

    for (genvar g = 0; g < OVL_NUM_RGN; g++) begin : g_win
        logic [5:0]            shamt;
        logic [OVL_ADDR_W-1:0] mask;
        logic [OVL_ADDR_W-1:0] base_b;
        logic [OVL_ADDR_W-1:0] low_b;
        logic                  valid;

        assign shamt  = {2'b00, desc[g].code} + 6'd2;
        assign mask   = {OVL_ADDR_W{1'b1}} << shamt;
        assign base_b = {desc[g].base_w, 2'b00};
        assign valid  = (desc[g].code != '0) &&
                        (desc[g].code <= OVL_CODE_W'(OVL_MAX_CODE));
        assign hit_v[g] = valid && (((addr ^ base_b) & mask) == '0);
        assign low_b    = addr & ~mask;
        assign off_a[g] = low_b[OVL_SLOT_AW-1:0];
    end

    // Lowest-numbered matching window wins.
    always_comb begin
        any_hit = |hit_v;
        hit_idx = '0;
        hit_off = '0;
        for (int i = OVL_NUM_RGN - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                hit_idx = OVL_RGN_W'(i);
                hit_off = off_a[i];
            end
        end
    end

endmodule

// File: rtl/ovl_resp_pipe.sv
module ovl_resp_pipe
    import cal_ovl_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  resp_t in_i,
    output resp_t out_o
);

    resp_t stg_d [DEPTH];
    resp_t stg_q [DEPTH];

    always_comb begin
        stg_d[0] = in_i;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign out_o = stg_q[DEPTH-1];

endmodule

// File: rtl/cal_overlay_remap.sv
module cal_overlay_remap
    import cal_ovl_pkg::*;
#(
    parameter int                    LAT       = 2,
    parameter logic [OVL_ADDR_W-1:0] CRAM_BASE = 32'h0030_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [OVL_RGN_W-1:0]  cfg_idx,
    input  logic [OVL_ADDR_W-1:0] cfg_base,
    input  logic [OVL_CODE_W-1:0] cfg_code,
    input  logic                  dis_we,
    input  logic                  dis_val,
    input  logic                  req_rd,
    input  logic                  req_wr,
    input  logic                  req_ifetch,
    input  logic [OVL_ADDR_W-1:0] req_addr,
    output logic                  ram_rd,
    output logic                  ram_wr,
    output logic [OVL_RAM_AW-1:0] ram_addr,
    output logic                  resp_hit,
    output logic [OVL_RGN_W-1:0]  resp_rgn,
    output logic                  resp_flash_blk,
    output logic                  resp_err
);

    localparam int PIPE_DEPTH = (LAT > 1) ? LAT - 1 : 1;

    rgn_desc_t              desc [OVL_NUM_RGN];
    logic                   dis;
    logic                   any_hit;
    logic [OVL_RGN_W-1:0]   hit_idx;
    logic [OVL_SLOT_AW-1:0] hit_off;
    front_t                 front_d, front_q;
    resp_t                  resp_out;

    ovl_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_base (cfg_base),
        .cfg_code (cfg_code),
        .dis_we   (dis_we),
        .dis_val  (dis_val),
        .desc_o   (desc),
        .dis_o    (dis)
    );

    ovl_window_match u_match (
        .desc    (desc),
        .addr    (req_addr),
        .any_hit (any_hit),
        .hit_idx (hit_idx),
        .hit_off (hit_off)
    );

    always_comb begin
        logic direct;
        logic rd;
        logic wr;
        direct  = (req_addr[OVL_ADDR_W-1:OVL_RAM_AW] == CRAM_BASE[OVL_ADDR_W-1:OVL_RAM_AW]);
        rd      = req_rd;
        wr      = req_wr && !req_rd;
        front_d = '0;
        if (direct) begin
            if (dis) begin
                front_d.resp.err = rd || wr;
            end else begin
                front_d.ram_rd   = rd;
                front_d.ram_wr   = wr;
                front_d.ram_addr = req_addr[OVL_RAM_AW-1:0];
            end
        end else if (rd && !req_ifetch && !dis && any_hit) begin
            front_d.ram_rd   = 1'b1;
            front_d.ram_addr = {hit_idx, hit_off};
            front_d.resp.hit = 1'b1;
            front_d.resp.rgn = hit_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            front_q <= '0;
        end else begin
            front_q <= front_d;
        end
    end

    ovl_resp_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (front_q.resp),
        .out_o (resp_out)
    );

    assign ram_rd         = front_q.ram_rd;
    assign ram_wr         = front_q.ram_wr;
    assign ram_addr       = front_q.ram_addr;
    assign resp_hit       = resp_out.hit;
    assign resp_rgn       = resp_out.rgn;
    assign resp_flash_blk = resp_out.hit;
    assign resp_err       = resp_out.err;

endmodule

// File: rtl/ovl_remap_chk.sv
module ovl_remap_chk (
    input logic clk,
    input logic rst_n,
    input logic req_rd,
    input logic req_wr,
    input logic ram_rd,
    input logic ram_wr,
    input logic resp_hit,
    input logic resp_err
);

    assert_rd_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> $past(req_rd));

    assert_wr_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> $past(req_wr));

    assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_rd, ram_wr}));

    assert_err_never_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> !resp_hit);

endmodule

bind cal_overlay_remap ovl_remap_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_rd   (req_rd),
    .req_wr   (req_wr),
    .ram_rd   (ram_rd),
    .ram_wr   (ram_wr),
    .resp_hit (resp_hit),
    .resp_err (resp_err)
);

// File: tb/sim_cal_overlay_remap.sv
module sim_cal_overlay_remap;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        fe;
        logic [31:0] addr;
        logic        e_rd;
        logic        e_wr;
        logic [11:0] e_ra;
        logic        e_hit;
        logic [2:0]  e_rg;
        logic        e_err;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,1'b0,1'b0,32'h0001_0004, 1'b1,1'b0,12'h004,1'b1,3'd0,1'b0,4'd3},  // R3 misaligned base rounded
        '{1'b1,1'b0,1'b0,32'h0001_007C, 1'b1,1'b0,12'h07C,1'b1,3'd0,1'b0,4'd2},  // R2 top of 128 B
        '{1'b1,1'b0,1'b0,32'h0001_0080, 1'b1,1'b0,12'h280,1'b1,3'd1,1'b0,4'd5},  // R5 past window 0, window 1
        '{1'b1,1'b0,1'b0,32'h0001_01FC, 1'b1,1'b0,12'h3FC,1'b1,3'd1,1'b0,4'd4},  // R4 slot 1 offset
        '{1'b1,1'b0,1'b0,32'h0001_0200, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b0,4'd2},  // R2 above 512 B
        '{1'b1,1'b0,1'b0,32'h0002_0004, 1'b1,1'b0,12'h404,1'b1,3'd2,1'b0,4'd4},  // R4 8 B window
        '{1'b1,1'b0,1'b0,32'h0002_0008, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b0,4'd2},  // R2 past 8 B
        '{1'b1,1'b0,1'b0,32'h0003_0000, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b0,4'd2},  // R2 code 0
        '{1'b1,1'b0,1'b0,32'h0004_0000, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b0,4'd2},  // R2 code 9
        '{1'b1,1'b0,1'b0,32'h0005_011C, 1'b1,1'b0,12'hA1C,1'b1,3'd5,1'b0,4'd4},  // R4 slot 5
        '{1'b1,1'b0,1'b0,32'h0005_00FC, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b0,4'd3},  // R3 below rounded base
        '{1'b1,1'b0,1'b1,32'h0001_0004, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b0,4'd6},  // R6 fetch
        '{1'b0,1'b1,1'b0,32'h0001_0004, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b0,4'd7},  // R7 write
        '{1'b1,1'b0,1'b0,32'h0030_0010, 1'b1,1'b0,12'h010,1'b0,3'd0,1'b0,4'd10}, // R10 direct read
        '{1'b0,1'b1,1'b0,32'h0030_0FFC, 1'b0,1'b1,12'hFFC,1'b0,3'd0,1'b0,4'd10}, // R10 direct write
        '{1'b1,1'b1,1'b1,32'h0030_0020, 1'b1,1'b0,12'h020,1'b0,3'd0,1'b0,4'd10}  // R10 fetch, rd+wr
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [3:0]  cfg_code = '0;
    logic        dis_we = 1'b0;
    logic        dis_val = 1'b0;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic        req_ifetch = 1'b0;
    logic [31:0] req_addr = '0;
    logic        ram_rd, ram_wr, resp_hit, resp_flash_blk, resp_err;
    logic [11:0] ram_addr;
    logic [2:0]  resp_rgn;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_overlay_remap #(.LAT(LAT), .CRAM_BASE(32'h0030_0000)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_code(cfg_code),
        .dis_we(dis_we), .dis_val(dis_val),
        .req_rd(req_rd), .req_wr(req_wr), .req_ifetch(req_ifetch), .req_addr(req_addr),
        .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
        .resp_hit(resp_hit), .resp_rgn(resp_rgn), .resp_flash_blk(resp_flash_blk),
        .resp_err(resp_err)
    );

    task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic write_rgn(input int idx, input logic [31:0] base, input logic [3:0] code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = base; cfg_code = code;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_dis(input logic v);
        @(negedge clk);
        dis_we = 1'b1; dis_val = v;
        @(negedge clk);
        dis_we = 1'b0;
    endtask

    // Drive one request, check strobes one cycle later and response LAT cycles later (R8).
    task automatic apply(input vec_t v);
        @(negedge clk);
        req_rd = v.rd; req_wr = v.wr; req_ifetch = v.fe; req_addr = v.addr;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0; req_ifetch = 1'b0;
        check(int'(v.rq), "ram_rd", 32'(ram_rd), 32'(v.e_rd));
        check(int'(v.rq), "ram_wr", 32'(ram_wr), 32'(v.e_wr));
        check(int'(v.rq), "ram_addr", 32'(ram_addr), 32'(v.e_ra));
        check(8, "resp_hit early", 32'(resp_hit), 32'd0);  // R8 not before LAT
        repeat (LAT-1) @(negedge clk);
        check(int'(v.rq), "resp_hit", 32'(resp_hit), 32'(v.e_hit));
        check(8, "resp_flash_blk", 32'(resp_flash_blk), 32'(v.e_hit));  // R8
        check(int'(v.rq), "resp_rgn", 32'(resp_rgn), 32'(v.e_rg));
        check(int'(v.rq), "resp_err", 32'(resp_err), 32'(v.e_err));
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, "reset ram_rd", 32'(ram_rd), 32'd0);
        check(1, "reset ram_wr", 32'(ram_wr), 32'd0);
        check(1, "reset resp_hit", 32'(resp_hit), 32'd0);
        check(1, "reset resp_err", 32'(resp_err), 32'd0);
        apply('{1'b1,1'b0,1'b0,32'h0001_0004, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b0,4'd1}); // R1

        write_rgn(0, 32'h0001_0040, 4'd5);
        write_rgn(1, 32'h0001_0000, 4'd7);
        write_rgn(2, 32'h0002_0000, 4'd1);
        write_rgn(3, 32'h0003_0000, 4'd0);
        write_rgn(4, 32'h0004_0000, 4'd9);
        write_rgn(5, 32'h0005_0104, 4'd3);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
        end

        // R9 disabled: no overlay, direct access errors
        write_dis(1'b1);
        apply('{1'b1,1'b0,1'b0,32'h0001_0004, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b0,4'd9});
        apply('{1'b1,1'b0,1'b0,32'h0030_0010, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b1,4'd9});
        apply('{1'b0,1'b1,1'b0,32'h0030_0010, 1'b0,1'b0,12'h000,1'b0,3'd0,1'b1,4'd9});
        // R9 cleared: normal again
        write_dis(1'b0);
        apply('{1'b1,1'b0,1'b0,32'h0001_0004, 1'b1,1'b0,12'h004,1'b1,3'd0,1'b0,4'd9});
        apply('{1'b1,1'b0,1'b0,32'h0030_0010, 1'b1,1'b0,12'h010,1'b0,3'd0,1'b0,4'd9});

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule